// File: doc/BRIEF.md
# Serial Divider and Control Programming Port

This block is the programming slave of a frequency synthesizer. A host drives three lines: a serial clock, a serial data line and an active-low frame enable. The block watches these lines with its own system clock, assembles a 17-bit frame and, when the enable line returns high, copies the frame's payload into one of five configuration latches. The latches hold two VCO divider words, two reference divider words and one 13-bit control word. Each latch drives its own parallel output, and a per-latch write pulse marks each update.

A frame is only accepted after the port has been armed. Arming takes one complete serial clock cycle, rising and then falling, while enable is still high. A complete transfer therefore takes 18 serial clock pulses. After every enable rise the port returns to the unarmed state.

Bit 0 of the control word is a soft run bit. Clearing it turns off the downstream core through `core_on`, but the serial port and all latches keep working. The hard power-down input is different. While it is high it clears every latch to its default, blocks the serial port and holds the core off.

Top module: `synth_prog_port`

## Requirements
- R1: After reset every latch output holds its default value, `wr_pulse` is zero and `core_on` is 1.
- R2: Frames are sent MSB first and are 17 bits long. Frame bits 16..3 form the payload and bits 2..0 form the address code, so the last three bits shifted in are the address. The write takes effect only after `ser_en` rises.
- R3: Address codes select the latches as follows: 0 is M1, 1 is M2, 2 is R1, 3 is R2 and 4 is the control word. The control word takes payload bits 12..0, and payload bit 13 is dropped. Codes 5, 6 and 7 change no latch and raise no strobe.
- R4: If `ser_en` falls without first seeing a complete serial clock cycle while it was high, the frame that follows is discarded.
- R5: Every accepted write raises exactly one `wr_pulse` bit, the bit whose index equals the address code, for exactly one system clock cycle.
- R6: A frame of fewer than 17 bits writes nothing and leaves the port unarmed. An unarmed full frame sent next is also discarded, while an armed one is accepted.
- R7: While control bit 0 is 0, `core_on` is 0, writes still land in the latches and the latches that were not written keep their values.
- R8: While `pwr_down` is high, all latches are at their defaults, no strobe rises, no frame is accepted and `core_on` is 0. After `pwr_down` is released the defaults remain until they are written.
- R9: A latch output changes only in a cycle in which its strobe is high or just after `pwr_down` was high.
- R10: The default values are: M1 0x0100, M2 0x0200, R1 0x0010, R2 0x0020, control 0x0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data | input | 1 | Serial data, MSB first |
| ser_en | input | 1 | Frame enable, active low; its rising edge commits the frame |
| pwr_down | input | 1 | Hard power-down, active high |
| m1_div | output | 14 | First VCO divider word |
| m2_div | output | 14 | Second VCO divider word |
| r1_div | output | 14 | First reference divider word |
| r2_div | output | 14 | Second reference divider word |
| ctrl_word | output | 13 | Control word; bit 0 is the run bit |
| wr_pulse | output | 5 | One-cycle write strobe per latch, indexed by address code |
| core_on | output | 1 | High when the core may run |

## Verification
The assertions assume that `pwr_down` is synchronous to `clk`, because they relate it to latch and strobe values one cycle later with no synchronizer delay. They also assume that the serial lines move slowly compared with `clk`, so that every serial edge is seen as a separate event after the input synchronizers. The bench changes `pwr_down` only on falling edges of `clk`. It holds every serial line level for four system clocks and sets up data half a serial period before each rising edge.

// File: rtl/sp3_pkg.sv
package sp3_pkg;

    localparam int FRAME_W     = 17;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = FRAME_W - ADDR_W;
    localparam int CTRL_W      = 13;
    localparam int NUM_LATCH   = 5;
    localparam int CNT_W       = $clog2(FRAME_W + 1);
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ARM_WAIT = 2'd0,
        ARMED    = 2'd1,
        SHIFTING = 2'd2
    } shift_state_e;

    typedef enum logic [ADDR_W-1:0] {
        SEL_M1   = 3'd0,
        SEL_M2   = 3'd1,
        SEL_R1   = 3'd2,
        SEL_R2   = 3'd3,
        SEL_CTRL = 3'd4
    } latch_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] payload;
        logic [ADDR_W-1:0] addr;
    } frame_t;

    typedef struct packed {
        logic   valid;
        frame_t frame;
    } commit_t;

    // Power-on contents of each latch, indexed by address code
    function automatic logic [DATA_W-1:0] latch_default(input int idx);
        case (idx)
            0:       return 14'h0100;
            1:       return 14'h0200;
            2:       return 14'h0010;
            3:       return 14'h0020;
            4:       return 14'h0001;
            default: return '0;
        endcase
    endfunction

    // Bits of the payload a latch actually keeps
    function automatic logic [DATA_W-1:0] latch_mask(input int idx);
        if (idx == int'(SEL_CTRL))
            return DATA_W'((1 << CTRL_W) - 1);
        return '1;
    endfunction

endpackage

// File: rtl/sp3_sync.sv
module sp3_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= '0;
                else     pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '0;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/sp3_shifter.sv
module sp3_shifter
    import sp3_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    flush,
    input  logic    sclk,
    input  logic    sdata,
    input  logic    sen,
    output commit_t commit
);
    shift_state_e       state;
    logic               sclk_d;
    logic               sen_d;
    logic               seen_rise;
    logic [CNT_W-1:0]   bit_cnt;
    logic [FRAME_W-1:0] shreg;

    logic sclk_rise, sclk_fall, sen_rise, sen_fall, frame_full;

    assign sclk_rise  =  sclk & ~sclk_d;
    assign sclk_fall  = ~sclk &  sclk_d;
    assign sen_rise   =  sen  & ~sen_d;
    assign sen_fall   = ~sen  &  sen_d;
    assign frame_full = (bit_cnt == CNT_W'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state     <= ARM_WAIT;
            sclk_d    <= sclk;
            sen_d     <= sen;
            seen_rise <= 1'b0;
            bit_cnt   <= '0;
            shreg     <= '0;
            commit    <= '0;
        end else begin
            sclk_d       <= sclk;
            sen_d        <= sen;
            commit.valid <= 1'b0;
            case (state)
                ARM_WAIT: begin
                    // a full serial cycle with enable high arms the port
                    if (!sen) begin
                        seen_rise <= 1'b0;
                    end else begin
                        if (sclk_rise)
                            seen_rise <= 1'b1;
                        if (sclk_fall && seen_rise)
                            state <= ARMED;
                    end
                end
                ARMED: begin
                    if (sen_fall) begin
                        state   <= SHIFTING;
                        bit_cnt <= '0;
                    end
                end
                SHIFTING: begin
                    if (sen_rise) begin
                        state     <= ARM_WAIT;
                        seen_rise <= 1'b0;
                        if (frame_full) begin
                            commit.valid <= 1'b1;
                            commit.frame <= frame_t'(shreg);
                        end
                    end else if (sclk_rise) begin
                        shreg <= {shreg[FRAME_W-2:0], sdata};
                        if (!frame_full)
                            bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ARM_WAIT;
            endcase
        end
    end
endmodule

// File: rtl/sp3_latch_bank.sv
module sp3_latch_bank
    import sp3_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    flush,
    input  commit_t                 commit,
    output logic [DATA_W-1:0]       latch_q [NUM_LATCH],
    output logic [NUM_LATCH-1:0]    strobe
);
    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
        logic hit;
        assign hit = commit.valid && (commit.frame.addr == ADDR_W'(g));

        always_ff @(posedge clk) begin
            if (rst || flush) begin
                latch_q[g] <= latch_default(g);
                strobe[g]  <= 1'b0;
            end else begin
                strobe[g] <= hit;
                if (hit)
                    latch_q[g] <= commit.frame.payload & latch_mask(g);
            end
        end
    end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import sp3_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_data,
    input  logic                 ser_en,
    input  logic                 pwr_down,
    output logic [DATA_W-1:0]    m1_div,
    output logic [DATA_W-1:0]    m2_div,
    output logic [DATA_W-1:0]    r1_div,
    output logic [DATA_W-1:0]    r2_div,
    output logic [CTRL_W-1:0]    ctrl_word,
    output logic [NUM_LATCH-1:0] wr_pulse,
    output logic                 core_on
);
    logic [2:0]        pins_sync;
    commit_t           commit;
    logic [DATA_W-1:0] latch_q [NUM_LATCH];
    logic              unused_ctrl_top;

    sp3_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_clk, ser_data, ser_en}),
        .q   (pins_sync)
    );

    sp3_shifter u_shift (
        .clk    (clk),
        .rst    (rst),
        .flush  (pwr_down),
        .sclk   (pins_sync[2]),
        .sdata  (pins_sync[1]),
        .sen    (pins_sync[0]),
        .commit (commit)
    );

    sp3_latch_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .flush   (pwr_down),
        .commit  (commit),
        .latch_q (latch_q),
        .strobe  (wr_pulse)
    );

    assign m1_div          = latch_q[SEL_M1];
    assign m2_div          = latch_q[SEL_M2];
    assign r1_div          = latch_q[SEL_R1];
    assign r2_div          = latch_q[SEL_R2];
    assign ctrl_word       = latch_q[SEL_CTRL][CTRL_W-1:0];
    assign unused_ctrl_top = latch_q[SEL_CTRL][DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) core_on <= latch_default(int'(SEL_CTRL)) != '0;
        else     core_on <= !pwr_down && ctrl_word[0];
    end
endmodule

// File: rtl/sp3_checker.sv
module sp3_checker
    import sp3_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 pwr_down,
    input logic [DATA_W-1:0]    m1_div,
    input logic [DATA_W-1:0]    m2_div,
    input logic [DATA_W-1:0]    r1_div,
    input logic [DATA_W-1:0]    r2_div,
    input logic [CTRL_W-1:0]    ctrl_word,
    input logic [NUM_LATCH-1:0] wr_pulse,
    input logic                 core_on
);
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_pulse));

    a_r8_hard_defaults: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (m1_div == latch_default(0) && m2_div == latch_default(1) &&
                      r1_div == latch_default(2) && r2_div == latch_default(3) &&
                      ctrl_word == latch_default(4)[CTRL_W-1:0]));

    a_r8_hard_no_strobe: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> (wr_pulse == '0));

    a_r8_hard_core_off: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> !core_on);

    a_r9_m1_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(m1_div) |-> (wr_pulse[0] || $past(pwr_down)));

    a_r9_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(r2_div) |-> (wr_pulse[3] || $past(pwr_down)));

    a_r9_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_word) |-> (wr_pulse[4] || $past(pwr_down)));
endmodule

bind synth_prog_port sp3_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_down  (pwr_down),
    .m1_div    (m1_div),
    .m2_div    (m2_div),
    .r1_div    (r1_div),
    .r2_div    (r2_div),
    .ctrl_word (ctrl_word),
    .wr_pulse  (wr_pulse),
    .core_on   (core_on)
);

// File: tb/synth_prog_port_test.sv
module synth_prog_port_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NVEC       = 8;

    // {expected strobe bits, payload, address}
    localparam logic [21:0] VEC [NVEC] = '{
        {5'b00001, 14'h1234, 3'd0},
        {5'b00010, 14'h0ABC, 3'd1},
        {5'b00100, 14'h3001, 3'd2},
        {5'b01000, 14'h2AAA, 3'd3},
        {5'b10000, 14'h1555, 3'd4},
        {5'b00000, 14'h3FFF, 3'd5},
        {5'b00000, 14'h0000, 3'd7},
        {5'b00001, 14'h0001, 3'd0}
    };

    logic clk = 0, rst = 1;
    logic ser_clk = 0, ser_data = 0, ser_en = 1, pwr_down = 0;
    logic [13:0] m1_div, m2_div, r1_div, r2_div;
    logic [12:0] ctrl_word;
    logic [4:0]  wr_pulse;
    logic        core_on;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [13:0] mdl [5];
    int pcnt [5];
    bit pclr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_prog_port uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .pwr_down(pwr_down), .m1_div(m1_div), .m2_div(m2_div),
        .r1_div(r1_div), .r2_div(r2_div), .ctrl_word(ctrl_word),
        .wr_pulse(wr_pulse), .core_on(core_on)
    );

    always @(negedge clk) begin
        for (int i = 0; i < 5; i++) begin
            if (pclr) pcnt[i] = 0;
            else if (wr_pulse[i]) pcnt[i] = pcnt[i] + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_sys(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulses();
        pclr = 1; wait_sys(1); pclr = 0;
    endtask

    task automatic send_frame(input logic [16:0] f, input bit arm, input int nbits);
        ser_en = 1; ser_clk = 0; wait_sys(HALF);
        if (arm) begin
            ser_clk = 1; wait_sys(HALF);
            ser_clk = 0; wait_sys(HALF);
        end
        ser_en = 0; wait_sys(HALF);
        for (int i = 0; i < nbits; i++) begin
            ser_data = f[16-i]; wait_sys(HALF);
            ser_clk = 1;        wait_sys(HALF);
            ser_clk = 0;
        end
        wait_sys(HALF);
        ser_en = 1;
        wait_sys(12);
    endtask

    task automatic check_latches(input string req);
        check({req, " m1"},   32'(m1_div),    32'(mdl[0]));
        check({req, " m2"},   32'(m2_div),    32'(mdl[1]));
        check({req, " r1"},   32'(r1_div),    32'(mdl[2]));
        check({req, " r2"},   32'(r2_div),    32'(mdl[3]));
        check({req, " ctrl"}, 32'(ctrl_word), 32'(mdl[4]));
    endtask

    task automatic check_pulses(input string req, input logic [4:0] exp);
        for (int i = 0; i < 5; i++)
            check(req, 32'(pcnt[i]), 32'(exp[i]));
    endtask

    task automatic model_defaults();
        mdl[0] = 14'h0100; mdl[1] = 14'h0200; mdl[2] = 14'h0010;
        mdl[3] = 14'h0020; mdl[4] = 14'h0001;
    endtask

    task automatic model_write(input logic [16:0] f);
        if (f[2:0] < 3'd5)
            mdl[f[2:0]] = (f[2:0] == 3'd4) ? (f[16:3] & 14'h1FFF) : f[16:3];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_defaults();
        clear_pulses();
        wait_sys(5);
        rst = 0;
        wait_sys(3);
        // R1 / R10: reset state and defaults
        check_latches("R1 R10 reset");
        check("R1 core_on", 32'(core_on), 32'd1);
        check_pulses("R1 no strobe", 5'b0);

        // R2 R3 R5: vector table
        for (int v = 0; v < NVEC; v++) begin
            clear_pulses();
            send_frame(VEC[v][16:0], 1, 17);
            model_write(VEC[v][16:0]);
            check_latches("R2 R3 table");
            check_pulses("R5 strobe", VEC[v][21:17]);
        end

        // R4: no arming cycle before enable falls
        clear_pulses();
        send_frame({14'h3FFF, 3'd0}, 0, 17);
        check_latches("R4 unarmed");
        check_pulses("R4 no strobe", 5'b0);

        // R6: short frame, then unarmed frame, then armed frame
        clear_pulses();
        send_frame({14'h2222, 3'd1}, 1, 10);
        check_latches("R6 short");
        send_frame({14'h2222, 3'd1}, 0, 17);
        check_latches("R6 after short unarmed");
        check_pulses("R6 no strobe", 5'b0);
        send_frame({14'h2222, 3'd1}, 1, 17);
        model_write({14'h2222, 3'd1});
        check_latches("R6 rearmed");

        // R7: soft run bit cleared, writes still land
        send_frame({14'h0000, 3'd4}, 1, 17);
        model_write({14'h0000, 3'd4});
        check("R7 core off", 32'(core_on), 32'd0);
        clear_pulses();
        send_frame({14'h0777, 3'd2}, 1, 17);
        model_write({14'h0777, 3'd2});
        check_latches("R7 soft write");
        check_pulses("R7 strobe", 5'b00100);
        // R3: payload bit 13 dropped for control word
        send_frame({14'h3FFF, 3'd4}, 1, 17);
        model_write({14'h3FFF, 3'd4});
        check("R3 ctrl mask", 32'(ctrl_word), 32'h1FFF);
        check("R7 core back on", 32'(core_on), 32'd1);

        // R8: hard power-down
        pwr_down = 1;
        wait_sys(3);
        model_defaults();
        check_latches("R8 in power-down");
        check("R8 core off", 32'(core_on), 32'd0);
        clear_pulses();
        send_frame({14'h1111, 3'd3}, 1, 17);
        check_latches("R8 write blocked");
        check_pulses("R8 no strobe", 5'b0);
        pwr_down = 0;
        wait_sys(3);
        check_latches("R8 after release");
        check("R8 core on after release", 32'(core_on), 32'd1);
        send_frame({14'h1111, 3'd3}, 1, 17);
        model_write({14'h1111, 3'd3});
        check_latches("R8 write after release");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule